// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block drives the command pins of an 8-bit SDRAM from the control side of an external memory interface. When the chip select is put into SDRAM mode, the sequencer brings the memory up without further prompting. It holds the clock enable low and sends no-operation commands for a programmable power-up time. It then sends a precharge-all, a fixed number of auto-refresh commands and, as the final step, a mode-register load. After that it reports ready. The sequence cannot be interrupted, and no access is granted while it runs.

In normal operation a refresh timer runs at a programmable period. Each expiry adds one request to a small pending count. A pending refresh goes out at the first cycle the shared bus is idle. The access path is stalled while a refresh is pending or in progress. Requests that arrive while the bus is busy collect in the pending count up to a fixed limit and are then sent one after another. Any expiry beyond that limit is dropped and sets a sticky overflow flag. Address multiplexing and data timing belong to the access path and are not part of this block. The access path is represented here only by its busy signal.

Top module: `sdr_ctl_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle or in its power-up wait, `cke` is low. The command is NOP, and `ready` and `grant` are low. Raising `sdram_en` starts the power-up wait, which lasts `pwrup_cycles`+1 cycles. The first command, precharge, appears on the pins `pwrup_cycles`+2 cycles after `sdram_en` is first driven high. From that command on, `cke` is high.
- R2: Command pin encodings, as {`cs_n`,`ras_n`,`cas_n`,`we_n`}: NOP=0111, precharge=0010, auto-refresh=0001, mode-register load=0000. The initialization order is precharge, then INIT_REFS (2) auto-refreshes, then a mode-register load. The gap from precharge to the first refresh is T_RP+1 cycles (3). Each refresh is followed by T_RFC+1 cycles (5) before the next command. `ready` rises T_MRD+1 cycles (3) after the load command.
- R3: `grant` is never high while `ready` is low. Once started, initialization runs to completion even if `sdram_en` falls and rises again during it.
- R4: In ready operation, with `refresh_period` = N > 0, refresh requests fall due every N cycles. A request is issued as an auto-refresh one cycle after it falls due if the bus is idle. `refresh_period` = 0 stops the timer.
- R5: While `bus_busy` is high in ready operation, no refresh is issued. Up to BACKLOG (4) requests are held. When the bus goes idle, the first held refresh is issued on the next cycle and the rest follow T_RFC+2 cycles (6) apart.
- R6: A request that falls due while BACKLOG requests are already held is dropped and sets `refresh_ovf`. The flag stays set until the next initialization starts, which clears it.
- R7: `grant` is high in ready operation exactly when no refresh is held or in progress.
- R8: When initialization completes, the refresh timer starts from zero and no held refresh survives from before. The first refresh after the load command comes T_MRD+N+2 cycles later.
- R9: Dropping `sdram_en` in ready operation with no refresh in progress returns the sequencer to idle. `ready` and `cke` go low, and any held refreshes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| sdram_en | input | 1 | Chip select configured for SDRAM; rising from idle starts initialization |
| pwrup_cycles | input | PUW | Power-up wait length, minus one |
| refresh_period | input | PERW | Refresh interval in cycles; 0 stops refresh |
| bus_busy | input | 1 | Shared bus occupied by another access |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | SDRAM clock enable |
| ready | output | 1 | Initialization complete |
| grant | output | 1 | Access path may start a transfer |
| refresh_ovf | output | 1 | Sticky: a refresh request was lost |

## Verification
The hardest case to reach is the saturated backlog. It needs several timer expiries while the bus stays busy, and then an orderly drain that no fresh expiry disturbs. The stimulus holds `bus_busy` for several periods so that the held count reaches its limit and the flag sets. It then releases the bus and sets the period to zero in the same cycle, so the drain shows exactly four refreshes at a fixed spacing. A second hard case is a full backlog at the moment the sequencer is disabled. The bench fills the backlog, drops the enable together with the busy signal, then initializes again and checks that the first refresh comes only after a full period.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_PRE,
        ST_PRE_W,
        ST_IAR,
        ST_IAR_W,
        ST_LMR,
        ST_LMR_W,
        ST_RUN,
        ST_RAR,
        ST_RAR_W
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_PRE,
        OP_REF,
        OP_LMR
    } sdr_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_pins_t;

    function automatic sdr_pins_t op_pins(sdr_op_e op);
        sdr_pins_t p;
        case (op)
            OP_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            OP_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            OP_LMR:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic logic is_ready_state(seq_state_e s);
        return (s == ST_RUN) || (s == ST_RAR) || (s == ST_RAR_W);
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sdr_refresh_backlog.sv
module sdr_refresh_backlog #(
    parameter int PERW    = 16,
    parameter int BACKLOG = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            clr_ovf,
    input  logic [PERW-1:0] period,
    input  logic            take,
    output logic            pend_nz,
    output logic            ovf
);
    localparam int CW = $clog2(BACKLOG + 1);
    localparam logic [CW-1:0] PMAX = CW'(BACKLOG);

    logic [PERW-1:0] rcnt;
    logic [CW-1:0]   pend;
    logic [CW-1:0]   pend_nx;
    logic            tick;
    logic            inc;
    logic            drop;

    assign tick = run && (period != '0) && (rcnt == period - 1'b1);
    assign inc  = tick && ((pend != PMAX) || take);
    assign drop = tick && (pend == PMAX) && !take;
    assign pend_nx = pend + CW'(inc) - CW'(take);

    always_ff @(posedge clk) begin
        if (rst || !run || period == '0)
            rcnt <= '0;
        else if (tick)
            rcnt <= '0;
        else
            rcnt <= rcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            pend <= '0;
        else
            pend <= pend_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_ovf)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
    end

    assign pend_nz = (pend != '0);

    p_pend_bound_r5: assert property (@(posedge clk) disable iff (rst)
        pend <= PMAX);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);

    p_take_needs_pend_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> pend_nz);

endmodule

// File: rtl/sdr_ctl_seq.sv
module sdr_ctl_seq
    import sdr_seq_pkg::*;
#(
    parameter int PUW       = 16,
    parameter int PERW      = 16,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 4,
    parameter int T_MRD     = 2,
    parameter int INIT_REFS = 2,
    parameter int BACKLOG   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sdram_en,
    input  logic [PUW-1:0]  pwrup_cycles,
    input  logic [PERW-1:0] refresh_period,
    input  logic            bus_busy,
    output logic            cs_n,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic            cke,
    output logic            ready,
    output logic            grant,
    output logic            refresh_ovf
);
    localparam int TW = PUW;
    localparam int RW = $clog2(INIT_REFS + 1);
    localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 1);
    localparam logic [TW-1:0] RFC_LD = TW'(T_RFC - 1);
    localparam logic [TW-1:0] MRD_LD = TW'(T_MRD - 1);
    localparam logic [RW-1:0] IREFS  = RW'(INIT_REFS);

    seq_state_e      state, state_nx;
    sdr_op_e         op;
    sdr_pins_t       pins;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_done;
    logic [RW-1:0]   irefs;
    logic            pend_nz;
    logic            take;
    logic            run;
    logic            init_start;

    assign run        = is_ready_state(state);
    assign take       = (state == ST_RUN) && sdram_en && pend_nz && !bus_busy;
    assign init_start = (state == ST_IDLE) && sdram_en;

    sdr_wait_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sdr_refresh_backlog #(.PERW(PERW), .BACKLOG(BACKLOG)) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clr_ovf (init_start),
        .period  (refresh_period),
        .take    (take),
        .pend_nz (pend_nz),
        .ovf     (refresh_ovf)
    );

    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (state)
            ST_IDLE:  if (sdram_en) begin
                          state_nx = ST_PWRUP;
                          t_load   = 1'b1;
                          t_val    = pwrup_cycles;
                      end
            ST_PWRUP: if (t_done) state_nx = ST_PRE;
            ST_PRE:   begin state_nx = ST_PRE_W; t_load = 1'b1; t_val = RP_LD; end
            ST_PRE_W: if (t_done) state_nx = ST_IAR;
            ST_IAR:   begin state_nx = ST_IAR_W; t_load = 1'b1; t_val = RFC_LD; end
            ST_IAR_W: if (t_done) state_nx = (irefs == IREFS) ? ST_LMR : ST_IAR;
            ST_LMR:   begin state_nx = ST_LMR_W; t_load = 1'b1; t_val = MRD_LD; end
            ST_LMR_W: if (t_done) state_nx = ST_RUN;
            ST_RUN:   if (!sdram_en) state_nx = ST_IDLE;
                      else if (take) state_nx = ST_RAR;
            ST_RAR:   begin state_nx = ST_RAR_W; t_load = 1'b1; t_val = RFC_LD; end
            ST_RAR_W: if (t_done) state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE)
            irefs <= '0;
        else if (state == ST_IAR)
            irefs <= irefs + 1'b1;
    end

    always_comb begin
        unique case (state)
            ST_PRE:         op = OP_PRE;
            ST_IAR, ST_RAR: op = OP_REF;
            ST_LMR:         op = OP_LMR;
            default:        op = OP_NOP;
        endcase
    end

    assign pins  = op_pins(op);
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign cke   = (state != ST_IDLE) && (state != ST_PWRUP);
    assign ready = run;
    assign grant = (state == ST_RUN) && !pend_nz;

    p_no_grant_init_r3: assert property (@(posedge clk) disable iff (rst)
        grant |-> ready);

    p_cke_pwrup_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRUP) |-> !cke);

    p_grant_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        grant |-> (ras_n && cas_n && we_n));

    p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && bus_busy) |=> (ras_n && cas_n));

    p_lmr_then_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LMR) |=> !ready);

endmodule

// File: tb/sdr_ctl_seq_test.sv
module sdr_ctl_seq_test;

    typedef struct {
        int    op;
        int    gap;
        string req;
    } exp_t;

    localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_LMR = 3, C_BAD = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        sdram_en;
    logic [15:0] pwrup_cycles;
    logic [15:0] refresh_period;
    logic        bus_busy;
    logic        cs_n, ras_n, cas_n, we_n, cke, ready, grant, refresh_ovf;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    int   last_t = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdr_ctl_seq uut (
        .clk(clk), .rst(rst), .sdram_en(sdram_en), .pwrup_cycles(pwrup_cycles),
        .refresh_period(refresh_period), .bus_busy(bus_busy),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ready(ready), .grant(grant), .refresh_ovf(refresh_ovf)
    );

    function automatic int decode(logic [3:0] p);
        case (p)
            4'b0111: return C_NOP;
            4'b0010: return C_PRE;
            4'b0001: return C_REF;
            4'b0000: return C_LMR;
            default: return C_BAD;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int op, input int gap, input string req);
        exp_t e;
        e.op = op; e.gap = gap; e.req = req;
        q.push_back(e);
    endtask

    task automatic mark();
        last_t = cyc;
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(q.size() == 0, "R2 sequence drain", q.size(), 0);
        q.delete();
    endtask

    // Monitor: every command on the pins is compared with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                int o;
                o = decode({cs_n, ras_n, cas_n, we_n});
                if (o != C_NOP) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R5 unexpected command", o, C_NOP);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(o == e.op, {e.req, " op"}, o, e.op);
                        chk(cyc - last_t == e.gap, {e.req, " gap"}, cyc - last_t, e.gap);
                    end
                    last_t = cyc;
                end
            end
        end
    end

    // Watchdog
    initial begin
        wait (cyc > 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic push_init();
        push(C_PRE, 7, "R1 precharge");
        push(C_REF, 3, "R2 init refresh 1");
        push(C_REF, 5, "R2 init refresh 2");
        push(C_LMR, 5, "R2 load mode");
    endtask

    initial begin
        rst = 1'b1; sdram_en = 1'b0; bus_busy = 1'b0;
        pwrup_cycles = 16'd5; refresh_period = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cke && !ready && !grant && !refresh_ovf, "R1 reset state", {cke, ready, grant, refresh_ovf}, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2 reset NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);

        // Phase 1: first initialization
        sdram_en = 1'b1; mark(); push_init();
        repeat (3) @(negedge clk);
        chk(!cke && !grant, "R1 power-up wait cke/grant", {cke, grant}, 0);
        wait_drain();
        repeat (3) @(negedge clk);
        chk(ready && cke && grant, "R2 ready after load", {ready, cke, grant}, 3'b111);

        // Periodic refresh
        refresh_period = 16'd30; mark();
        push(C_REF, 31, "R4 first periodic refresh");
        push(C_REF, 30, "R4 second periodic refresh");
        wait_drain();
        @(negedge clk);
        bus_busy = 1'b1;
        repeat (200) @(negedge clk);
        chk(!grant, "R7 grant low while held", grant, 0);
        chk(refresh_ovf, "R6 overflow set", refresh_ovf, 1);
        bus_busy = 1'b0; refresh_period = 16'd0; mark();
        push(C_REF, 1, "R5 drain 1");
        push(C_REF, 6, "R5 drain 2");
        push(C_REF, 6, "R5 drain 3");
        push(C_REF, 6, "R5 drain 4");
        wait_drain();
        repeat (20) @(negedge clk);
        chk(grant, "R7 grant after drain", grant, 1);
        chk(refresh_ovf, "R6 overflow sticky", refresh_ovf, 1);

        // Phase 2: disable, then re-init with enable glitch
        sdram_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(!ready && !cke && !grant, "R9 idle after disable", {ready, cke, grant}, 0);
        sdram_en = 1'b1; mark(); push_init();
        repeat (2) @(negedge clk);
        chk(!refresh_ovf, "R6 overflow cleared at init", refresh_ovf, 0);
        sdram_en = 1'b0;
        repeat (3) @(negedge clk);
        sdram_en = 1'b1;
        wait_drain();
        repeat (3) @(negedge clk);
        chk(ready, "R3 init not interrupted", ready, 1);

        // Phase 3: full backlog discarded by disable
        refresh_period = 16'd10; bus_busy = 1'b1;
        repeat (60) @(negedge clk);
        chk(refresh_ovf, "R6 overflow set again", refresh_ovf, 1);
        sdram_en = 1'b0; bus_busy = 1'b0;
        repeat (5) @(negedge clk);
        chk(!ready && !cke, "R9 backlog discarded idle", {ready, cke}, 0);
        sdram_en = 1'b1; mark(); push_init();
        push(C_REF, 14, "R8 first refresh after init");
        push(C_REF, 10, "R4 period ten");
        wait_drain();
        chk(!refresh_ovf, "R6 overflow clear after re-init", refresh_ovf, 0);
        sdram_en = 1'b0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule